// File: doc/BRIEF.md
# Two-Client Fair Arbiter with Same-Cycle Grants

This block shares one resource between two clients. Each client raises a request line and receives a grant line. Grants are combinational: a grant may rise in the same cycle as its request, and the state register only records who owns the resource and who won last. When both clients ask while the resource is free, the client served less recently wins.

When the owner drops its request while the other client is waiting, ownership passes straight to the waiting client in that cycle. No idle cycle sits between the two owners. When the owner drops its request and nobody is waiting, the block goes idle and remembers that the other client now has priority on a tie. A synchronous active-high reset returns the block to the idle state in which client 0 wins a tie.

Top module: `fair_arb2`

## Requirements
- R1: At most one of `gnt0` and `gnt1` is high in any cycle.
- R2: After a synchronous reset the block is idle and favours client 0. With both requests high in the first cycle after reset, `gnt0` is high and `gnt1` is low.
- R3: Grants are combinational. In an idle state, a request with no competing request wins in the same cycle it is raised.
- R4: In idle with both requests high, the client not served most recently wins. After client 0 owns and releases with no waiter, a tie goes to client 1. After client 1 owns and releases with no waiter, a tie goes to client 0.
- R5: While a client owns the resource and keeps its request high, it keeps its grant whatever the other request does.
- R6: When the owner's request is low and the other request is high, the other client is granted in that same cycle. On the next cycle it owns the resource with no idle cycle in between.
- R7: When the owner's request is low and the other request is low, both grants are low. The block goes idle and favours the other client.
- R8: With both requests low, both grants are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req0 | input | 1 | Request from client 0 |
| req1 | input | 1 | Request from client 1 |
| gnt0 | output | 1 | Grant to client 0 (combinational) |
| gnt1 | output | 1 | Grant to client 1 (combinational) |

## Verification
A release by the owner and the start of the other client's grant happen in the same cycle: the owner's request falls while the waiter's request is already high. The bench creates this case repeatedly with back-to-back handoffs in both directions. It compares both grants on every cycle with a behavioural model that tracks the owner and the client last served. The bench also makes the tie-break and the handoff coincide, with both requests rising together just after an idle release, so that each idle flavour is judged against the model.

// File: rtl/fair_arb2.sv
module fair_arb2 (
  input  logic clk,
  input  logic rst,
  input  logic req0,
  input  logic req1,
  output logic gnt0,
  output logic gnt1
);
  typedef enum logic [1:0] {IDLE_P0 = 2'b00, IDLE_P1 = 2'b01, OWN0 = 2'b10, OWN1 = 2'b11} st_t;
  st_t st, st_nx;

  assign gnt0 = ((st == IDLE_P0) && req0) ||
                ((st == IDLE_P1) && req0 && !req1) ||
                ((st == OWN0) && req0) ||
                ((st == OWN1) && !req1 && req0);
  assign gnt1 = ((st == IDLE_P1) && req1) ||
                ((st == IDLE_P0) && req1 && !req0) ||
                ((st == OWN1) && req1) ||
                ((st == OWN0) && !req0 && req1);

  always_comb begin
    case (st)
      IDLE_P0: st_nx = req0 ? OWN0 : (req1 ? OWN1 : IDLE_P0);
      IDLE_P1: st_nx = req1 ? OWN1 : (req0 ? OWN0 : IDLE_P1);
      OWN0:    st_nx = req0 ? OWN0 : (req1 ? OWN1 : IDLE_P1);
      default: st_nx = req1 ? OWN1 : (req0 ? OWN0 : IDLE_P0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= IDLE_P0;
    else     st <= st_nx;
  end
endmodule

module fair_arb2_chk (
  input logic clk,
  input logic rst,
  input logic req0,
  input logic req1,
  input logic gnt0,
  input logic gnt1
);
  p_mutex_r1: assert property (@(posedge clk) disable iff (rst) !(gnt0 && gnt1));
  p_hold0_r5: assert property (@(posedge clk) disable iff (rst) (gnt0 && req0) |=> (req0 -> gnt0));
  p_hold1_r5: assert property (@(posedge clk) disable iff (rst) (gnt1 && req1) |=> (req1 -> gnt1));
  p_hand01_r6: assert property (@(posedge clk) disable iff (rst) (gnt0 && req0) |=> ((!req0 && req1) -> gnt1));
  p_hand10_r6: assert property (@(posedge clk) disable iff (rst) (gnt1 && req1) |=> ((!req1 && req0) -> gnt0));
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst) (!req0 && !req1) |-> (!gnt0 && !gnt1));
  p_solo_r3: assert property (@(posedge clk) disable iff (rst) (req0 ^ req1) |-> (gnt0 == req0 && gnt1 == req1));
endmodule

bind fair_arb2 fair_arb2_chk u_chk (.*);

// File: tb/tb_fair_arb2.sv
module tb_fair_arb2;
  logic clk = 0, rst = 1, req0 = 0, req1 = 0;
  logic gnt0, gnt1;
  int checks = 0, errors = 0;
  int owner = -1;
  int last = 1;
  bit done = 0;

  fair_arb2 dut (.clk(clk), .rst(rst), .req0(req0), .req1(req1), .gnt0(gnt0), .gnt1(gnt1));

  always #2 clk = ~clk;

  function automatic int pick(bit a, bit b);
    if (owner == 0 && a) return 0;
    if (owner == 1 && b) return 1;
    if (owner >= 0) return (owner == 0) ? (b ? 1 : -1) : (a ? 0 : -1);
    if (a && b) return (last == 0) ? 1 : 0;
    if (a) return 0;
    if (b) return 1;
    return -1;
  endfunction

  task automatic cmp(string tag);
    int w;
    bit e0, e1;
    w = pick(req0, req1);
    e0 = (w == 0);
    e1 = (w == 1);
    checks++;
    if (gnt0 !== e0 || gnt1 !== e1) begin
      errors++;
      $display("FAIL %s g0g1=%b%b exp %b%b", tag, gnt0, gnt1, e0, e1);
    end
  endtask

  task automatic step(bit a, bit b, string tag);
    req0 = a; req1 = b;
    #1;
    cmp(tag);
    @(posedge clk);
    begin
      int w;
      w = pick(a, b);
      if (w >= 0) last = w;
      owner = w;
    end
    #1;
  endtask

  initial begin
    #400;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst = 0;
    owner = -1; last = 1;
    step(1, 1, "R2 tie after reset");
    step(0, 0, "R7 release idle");
    step(1, 1, "R4 tie favours 1");
    step(1, 1, "R5 hold 1");
    step(0, 1, "R5 hold 1 alone");
    step(1, 0, "R6 handoff 1->0");
    step(1, 1, "R5 hold 0");
    step(0, 1, "R6 handoff 0->1");
    step(1, 0, "R6 handoff 1->0 back");
    step(0, 1, "R6 back-to-back");
    step(0, 0, "R8 quiet");
    step(1, 1, "R4 tie favours 0");
    step(0, 0, "R7 release");
    step(0, 1, "R3 solo 1");
    step(0, 0, "R8 quiet");
    step(1, 0, "R3 solo 0");
    step(1, 1, "R1 both while owned");
    step(0, 0, "R7 idle");
    for (int i = 0; i < 40; i++) step(i[0] ^ i[2], i[1] | i[3], "R1 mixed");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule